// File: doc/BRIEF.md
# Condition Evaluator with Conditional Select

This block holds a four-flag condition register (carry, signed overflow, negative, zero) and evaluates one of eight condition codes against it. A single evaluator result feeds two consumers. A conditional jump raises a registered taken indication and presents the jump target. A three-register conditional move writes one of two source values to the destination: the first when the condition holds, the second when it does not.

The flags are loaded from the arithmetic unit. A separate request complements all four flags in place. Operations are qualified by `op_valid_i`. An operation always evaluates the flags as they stood before the clock edge that captures its result. As a consequence, a branch can be built from a conditional move of two addresses followed by an unconditional jump, and that branch lands on the same address as the direct conditional jump.

Top module: `cond_select_top`

## Requirements
- R1: While reset is applied and after it is released, the flags read 0, and `move_valid_o` and `branch_taken_o` read 0 until the first operation.
- R2: Flag bit positions are carry=bit0, overflow=bit1, negative=bit2, zero=bit3. Code 0 is true when carry is set. Code 1 is true when negative differs from overflow. Code 4 is true when negative is set. Code 5 is true when zero is set.
- R3: Code 2 (unsigned greater) is true when carry and zero are both clear.
- R4: Code 3 (signed greater) is true when negative equals overflow and zero is clear.
- R5: Codes 6 and 7 are always false.
- R6: One cycle after `op_valid_i` with `op_is_jump_i`=0, `move_valid_o` is 1. In that same cycle, `move_data_o` equals `src_true_i` if the condition held and `src_false_i` otherwise.
- R7: One cycle after `op_valid_i` with `op_is_jump_i`=1, `branch_taken_o` equals the condition. When the condition held, `branch_target_o` equals `jump_target_i`.
- R8: `flags_invert_i` complements all four flags on the next edge. If `flags_load_i` is also asserted, the load wins.
- R9: `flags_load_i` stores `flags_i` on the next edge. An operation issued in the same cycle as a load uses the flags from before the load.
- R10: In a cycle without `op_valid_i`, both valid outputs are 0 the next cycle. A move never raises `branch_taken_o`, and a jump never raises `move_valid_o`.
- R11: Under the same flags and code, a conditional move of (target, fall-through) returns the address that the direct conditional jump reaches: its target when taken, the fall-through otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flags_load_i | input | 1 | Load the condition flags |
| flags_i | input | 4 | New flags {zero, negative, overflow, carry} |
| flags_invert_i | input | 1 | Complement all flags |
| op_valid_i | input | 1 | Operation present this cycle |
| op_is_jump_i | input | 1 | 1 = conditional jump, 0 = conditional move |
| cond_code_i | input | 3 | Condition selector |
| src_true_i | input | DATA_W | Move source used when the condition holds |
| src_false_i | input | DATA_W | Move source used when it does not |
| jump_target_i | input | ADDR_W | Jump destination |
| move_valid_o | output | 1 | Move result present |
| move_data_o | output | DATA_W | Value written to the destination register |
| branch_taken_o | output | 1 | Jump taken |
| branch_target_o | output | ADDR_W | Redirect address |
| flags_o | output | 4 | Current condition flags |

## Verification
The assertions assume that every control input is a known 0 or 1 at every edge after reset. They also assume the flags and the condition code are never unknown while an operation is valid. The bench drives all inputs to defined values from time zero and changes them only on the falling edge. It holds operations off until the synchronised reset has been released. The stimulus sweeps all sixteen flag values against all eight codes, for both moves and jumps, and mixes in load-plus-invert and load-plus-operation cycles.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int FLAG_W = 4;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf;
    logic carry;
  } flags_t;

  typedef enum logic [CODE_W-1:0] {
    CC_CARRY = 3'd0,
    CC_SLT   = 3'd1,
    CC_UGT   = 3'd2,
    CC_SGT   = 3'd3,
    CC_NEG   = 3'd4,
    CC_ZERO  = 3'd5,
    CC_NONE6 = 3'd6,
    CC_NONE7 = 3'd7
  } cond_code_t;
endpackage

// File: rtl/cond_rst_sync.sv
module cond_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cond_flags_reg.sv
module cond_flags_reg
  import cond_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  flags_t flags_i,
  input  logic   invert_i,
  output flags_t flags_o
);
  flags_t flags_q, flags_d;
  logic   flags_en;

  assign flags_en = load_i | invert_i;

  always_comb begin
    flags_d = flags_q;
    if (load_i)        flags_d = flags_i;
    else if (invert_i) flags_d = ~flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_FLAG_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (invert_i && !load_i) |=> (flags_o == ~$past(flags_o))); // R8
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (flags_o == $past(flags_i))); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !invert_i) |=> $stable(flags_o)); // R9
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
(
  input  flags_t            flags_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              true_o
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int NUM_REAL  = 6;

  logic [NUM_CODES-1:0] cond_vec;
  logic                 lt_signed;

  assign lt_signed = flags_i.neg ^ flags_i.ovf;

  assign cond_vec[CC_CARRY] = flags_i.carry;
  assign cond_vec[CC_SLT]   = lt_signed;
  assign cond_vec[CC_UGT]   = ~flags_i.carry & ~flags_i.zero;
  assign cond_vec[CC_SGT]   = ~lt_signed & ~flags_i.zero;
  assign cond_vec[CC_NEG]   = flags_i.neg;
  assign cond_vec[CC_ZERO]  = flags_i.zero;

  generate
    for (genvar i = NUM_REAL; i < NUM_CODES; i++) begin : g_never
      assign cond_vec[i] = 1'b0;
    end
  endgenerate

  assign true_o = cond_vec[code_i];

  always_comb begin
    AST_RESERVED_FALSE: assert (!(code_i >= CODE_W'(NUM_REAL) && true_o)); // R5
    AST_UGT_EXCL: assert (!(cond_vec[CC_UGT] && (cond_vec[CC_CARRY] || cond_vec[CC_ZERO]))); // R3
    AST_SGT_EXCL: assert (!(cond_vec[CC_SGT] && (cond_vec[CC_SLT] || cond_vec[CC_ZERO]))); // R4
  end
endmodule

// File: rtl/cond_select_top.sv
module cond_select_top
  import cond_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flags_load_i,
  input  logic [3:0]        flags_i,
  input  logic              flags_invert_i,
  input  logic              op_valid_i,
  input  logic              op_is_jump_i,
  input  logic [2:0]        cond_code_i,
  input  logic [DATA_W-1:0] src_true_i,
  input  logic [DATA_W-1:0] src_false_i,
  input  logic [ADDR_W-1:0] jump_target_i,
  output logic              move_valid_o,
  output logic [DATA_W-1:0] move_data_o,
  output logic              branch_taken_o,
  output logic [ADDR_W-1:0] branch_target_o,
  output logic [3:0]        flags_o
);
  logic        rst_sync_n;
  flags_t      flags_cur;
  logic        cond_true;

  logic              mv_valid_q, mv_valid_d;
  logic [DATA_W-1:0] mv_data_q, mv_data_d;
  logic              br_taken_q, br_taken_d;
  logic [ADDR_W-1:0] br_tgt_q, br_tgt_d;
  logic              mv_en, br_en;

  cond_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n)
  );

  cond_flags_reg u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .load_i(flags_load_i), .flags_i(flags_t'(flags_i)),
    .invert_i(flags_invert_i), .flags_o(flags_cur)
  );

  cond_eval u_eval (
    .flags_i(flags_cur), .code_i(cond_code_i), .true_o(cond_true)
  );

  assign mv_en = op_valid_i & ~op_is_jump_i;
  assign br_en = op_valid_i &  op_is_jump_i;

  always_comb begin
    mv_valid_d = mv_en;
    br_taken_d = br_en & cond_true;
    mv_data_d  = cond_true ? src_true_i : src_false_i;
    br_tgt_d   = jump_target_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mv_valid_q <= 1'b0;
      br_taken_q <= 1'b0;
    end else begin
      mv_valid_q <= mv_valid_d;
      br_taken_q <= br_taken_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mv_data_q <= '0;
    else if (mv_en)   mv_data_q <= mv_data_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  br_tgt_q <= '0;
    else if (br_en)   br_tgt_q <= br_tgt_d;
  end

  assign move_valid_o    = mv_valid_q;
  assign move_data_o     = mv_data_q;
  assign branch_taken_o  = br_taken_q;
  assign branch_target_o = br_tgt_q;
  assign flags_o         = flags_cur;

  AST_MOVE_TRUE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mv_en && cond_true) |=> (move_valid_o && move_data_o == $past(src_true_i))); // R6
  AST_MOVE_FALSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mv_en && !cond_true) |=> (move_valid_o && move_data_o == $past(src_false_i))); // R6
  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_en && cond_true) |=> (branch_taken_o && branch_target_o == $past(jump_target_i))); // R7
  AST_MOVE_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && !op_is_jump_i) |=> !branch_taken_o); // R10
  AST_JUMP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_is_jump_i) |=> !move_valid_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid_i |=> (!move_valid_o && !branch_taken_o)); // R10
endmodule

// File: tb/cond_select_top_test.sv
module cond_select_top_test;
  localparam int  DW = 32;
  localparam int  AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flags_load, flags_invert, op_valid, op_is_jump;
  logic [3:0]    flags_in;
  logic [2:0]    code;
  logic [DW-1:0] src_t, src_f;
  logic [AW-1:0] tgt;
  logic          move_valid, branch_taken;
  logic [DW-1:0] move_data;
  logic [AW-1:0] branch_target;
  logic [3:0]    flags_out;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [3:0]    m_flags;
  logic          m_mv, m_bt;
  logic [DW-1:0] m_md;
  logic [AW-1:0] m_tg;
  logic [DW-1:0] last_move;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_select_top #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .flags_load_i(flags_load), .flags_i(flags_in), .flags_invert_i(flags_invert),
    .op_valid_i(op_valid), .op_is_jump_i(op_is_jump), .cond_code_i(code),
    .src_true_i(src_t), .src_false_i(src_f), .jump_target_i(tgt),
    .move_valid_o(move_valid), .move_data_o(move_data),
    .branch_taken_o(branch_taken), .branch_target_o(branch_target),
    .flags_o(flags_out)
  );

  // flags bits: 0 carry, 1 overflow, 2 negative, 3 zero
  function automatic logic ref_cond(logic [3:0] f, logic [2:0] c);
    logic cy, ov, ng, zr;
    cy = f[0]; ov = f[1]; ng = f[2]; zr = f[3];
    case (c)
      3'd0: return cy;
      3'd1: return (ng != ov);
      3'd2: return (cy == 1'b0) && (zr == 1'b0);
      3'd3: return (ng == ov) && (zr == 1'b0);
      3'd4: return ng;
      3'd5: return zr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_tag(logic [2:0] c);
    if (c == 3'd2) return "R3";
    if (c == 3'd3) return "R4";
    if (c >= 3'd6) return "R5";
    return "R2";
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    chk(flags_out == m_flags, {tag, "/R9 flags"}, 64'(flags_out), 64'(m_flags));
    chk(move_valid == m_mv, {tag, "/R10 move_valid"}, 64'(move_valid), 64'(m_mv));
    chk(branch_taken == m_bt, {tag, "/R10 taken"}, 64'(branch_taken), 64'(m_bt));
    if (m_mv) chk(move_data == m_md, {tag, "/R6 data"}, 64'(move_data), 64'(m_md));
    if (m_bt) chk(branch_target == m_tg, {tag, "/R7 target"}, 64'(branch_target), 64'(m_tg));
  endtask

  // one clock: drive at falling edge, compare at next falling edge
  task automatic step(logic ld, logic [3:0] fi, logic inv, logic v, logic j,
                      logic [2:0] c, logic [DW-1:0] st, logic [DW-1:0] sf,
                      logic [AW-1:0] t, string tag);
    logic ct;
    flags_load = ld; flags_in = fi; flags_invert = inv;
    op_valid = v; op_is_jump = j; code = c;
    src_t = st; src_f = sf; tgt = t;
    ct = ref_cond(m_flags, c);
    m_mv = v && !j;
    m_bt = v && j && ct;
    if (v && !j) m_md = ct ? st : sf;
    if (v && j && ct) m_tg = t;
    if (ld) m_flags = fi;
    else if (inv) m_flags = ~m_flags;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flags_load = 0; flags_in = 0; flags_invert = 0;
    op_valid = 0; op_is_jump = 0; code = 0;
    src_t = 0; src_f = 0; tgt = 0;
    m_flags = 0; m_mv = 0; m_bt = 0; m_md = 0; m_tg = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1 after release");

    // sweep every flag value and code, move then jump, check equivalence
    for (int f = 0; f < 16; f++) begin
      step(1, 4'(f), 0, 0, 0, 0, 0, 0, 0, "R9 load");
      for (int c = 0; c < 8; c++) begin
        logic [DW-1:0] ta, fb;
        logic          exp_c;
        ta = 32'h1000_0000 + 32'(f * 16 + c);
        fb = 32'h2000_0000 + 32'(f * 16 + c);
        exp_c = ref_cond(4'(f), 3'(c));
        step(0, 0, 0, 1, 0, 3'(c), ta, fb, 0, {"R6 move ", code_tag(3'(c))});
        chk(move_data == (exp_c ? ta : fb), {code_tag(3'(c)), " cond via move"},
            64'(move_data), 64'(exp_c ? ta : fb));
        last_move = move_data;
        step(0, 0, 0, 1, 1, 3'(c), 0, 0, ta, {"R7 jump ", code_tag(3'(c))});
        chk(branch_taken == exp_c, {code_tag(3'(c)), " cond via jump"},
            64'(branch_taken), 64'(exp_c));
        chk(last_move == (branch_taken ? branch_target : fb), "R11 emulated branch",
            64'(last_move), 64'(branch_taken ? branch_target : fb));
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    end

    // invert and priority
    step(1, 4'b0101, 0, 0, 0, 0, 0, 0, 0, "R9 load");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R8 invert");
    chk(flags_out == 4'b1010, "R8 complement", 64'(flags_out), 64'hA);
    step(0, 0, 1, 1, 0, 3'd5, 32'hAAAA, 32'hBBBB, 0, "R8 invert with move");
    chk(flags_out == 4'b0101 && move_data == 32'hAAAA, "R8 op uses pre-invert flags",
        64'(move_data), 64'hAAAA);
    step(1, 4'b0011, 1, 0, 0, 0, 0, 0, 0, "R8 load wins");
    chk(flags_out == 4'b0011, "R8 load priority", 64'(flags_out), 64'h3);
    // same-cycle load and jump: code 5 sees zero=0 before load
    step(1, 4'b1000, 0, 1, 1, 3'd5, 0, 0, 32'hCAFE, "R9 load with jump");
    chk(branch_taken == 1'b0, "R9 op uses old flags", 64'(branch_taken), 0);
    step(0, 0, 0, 1, 1, 3'd5, 0, 0, 32'hBEEF, "R9 after load");
    chk(branch_taken && branch_target == 32'hBEEF, "R7 taken on new flags",
        64'(branch_target), 64'hBEEF);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule